// File: doc/BRIEF.md
# Configuration Fuse and Lock Command Controller

This block sits on a simple register bus and runs commands against a small set of non-volatile configuration bytes. Software writes a 7-bit command code, a byte index and a data byte, then sets the execute bit to launch the command. Three codes are understood. A no-operation does nothing. A fuse read copies one fuse byte into the data register. A lock write lowers the lock byte. The fuse bytes and the lock byte live in internal registers that load fixed values at reset.

A lock write is guarded. It launches only if software first writes an unlock key to a protection register, which opens a short acceptance window. While a lock write runs, the block holds the processor halted. When the lock write ends, the block sends a one-cycle pulse that tells the page buffers to clear. A busy flag covers every command that actually runs. Register writes are refused while that flag is high.

Top module: `nvm_cfg_ctrl`

## Requirements
- R1: Register addresses are 0 command (7 bits, bit 7 reads 0), 1 control (bit 0 execute), 2 index, 3 data, 4 status (bit 0 busy), 5 lock byte (read only) and 6 protection key (write only, reads 0). Address 7 reads 0.
- R2: Command 0x07 followed by an execute write starts a fuse read. Two cycles later the data register holds fuse byte [index]. The fuse defaults are byte0=0xE7, byte1=0x7E, byte2=0x0F, byte3=0xF0, byte4=0x3C and byte5=0xA5. An index of 6 or more returns 0xFF.
- R3: Command 0x08 launches only if key 0x5A was written to address 6 during one of the 4 preceding clock edges. Without that key, the execute write is ignored.
- R4: `busy` and status bit 0 are high from the edge after the launch for exactly the command length. That length is 2 cycles for a fuse read and LOCK_CYCLES (16) cycles for a lock write.
- R5: `cpu_halt` is high exactly while a lock write runs. It is never high during a fuse read.
- R6: A lock write sets the lock byte to the old lock byte AND the data register, so no lock bit can ever return from 0 to 1.
- R7: `pgbuf_clr` pulses for one cycle in the cycle right after a lock write completes. It does not pulse at any other time.
- R8: While busy is high, every register write is ignored, including writes to the command, index, data and key registers.
- R9: The execute bit reads 1 while a command runs and 0 once it has finished. Code 0x00 and any undefined code never set busy.
- R10: After reset, busy, `cpu_halt` and `pgbuf_clr` are 0, the lock byte is 0xFF, and the command, index and data registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| busy | output | 1 | A command is running |
| cpu_halt | output | 1 | Processor halt request during a lock write |
| pgbuf_clr | output | 1 | One-cycle page-buffer clear pulse |
| lock_bits | output | 8 | Current lock byte |

## Verification
Fuse reads go to in-range and out-of-range indices. These show whether the index is really decoded, and whether the data register changes in the cycle that follows the 2-cycle latency and not one cycle early or late. Lock writes are launched with no key and with the key at several distances before the execute write. These distances are inside the window, at its last edge and one edge past it, so an off-by-one in the window length becomes visible. Lock values are written once with 0 bits that clear lock bits, and once with all 1s, which must leave the lock unchanged. Register writes issued during a run must leave every register unchanged.

// File: rtl/nvmc_pkg.sv
// Shared codes and register addresses for the configuration command controller.
package nvmc_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [6:0] {
        CMD_NOP     = 7'h00,
        CMD_RD_FUSE = 7'h07,
        CMD_WR_LOCK = 7'h08
    } cmd_e;

    localparam logic [REG_AW-1:0] A_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] A_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] A_IDX  = 3'd2;
    localparam logic [REG_AW-1:0] A_DATA = 3'd3;
    localparam logic [REG_AW-1:0] A_STAT = 3'd4;
    localparam logic [REG_AW-1:0] A_LOCK = 3'd5;
    localparam logic [REG_AW-1:0] A_KEY  = 3'd6;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_LOCK
    } seq_e;
endpackage

// File: rtl/nvmc_unlock_win.sv
// Unlock window: a key hit opens a window of WIN_LEN clock edges.
// Assumes the caller has already qualified key_hit (correct key, bus not busy).
module nvmc_unlock_win #(
    parameter int WIN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    output logic win_open
);
    localparam int CW = $clog2(WIN_LEN + 1);

    logic [CW-1:0] cnt_q;

    // Reload the counter on a key hit, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (key_hit) begin
            cnt_q <= CW'(WIN_LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign win_open = (cnt_q != '0);
endmodule

// File: rtl/nvmc_seq.sv
// Command sequencer: runs one command at a time for a fixed number of cycles.
// Assumes the start inputs arrive only while busy is low and are never both high.
module nvmc_seq
    import nvmc_pkg::*;
#(
    parameter int READ_LAT    = 2,
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_lk,
    output logic busy,
    output logic halt,
    output logic done_rd,
    output logic done_lk
);
    localparam int MAXC = (LOCK_CYCLES > READ_LAT) ? LOCK_CYCLES : READ_LAT;
    localparam int CW   = $clog2(MAXC + 1);

    seq_e          st_q;
    logic [CW-1:0] left_q;
    logic          last;

    // State and remaining-cycle counter of the running command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            left_q <= '0;
        end else if (st_q == SQ_IDLE) begin
            if (start_rd) begin
                st_q   <= SQ_READ;
                left_q <= CW'(READ_LAT);
            end else if (start_lk) begin
                st_q   <= SQ_LOCK;
                left_q <= CW'(LOCK_CYCLES);
            end
        end else if (last) begin
            st_q   <= SQ_IDLE;
            left_q <= '0;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end

    // Completion strobes and status, decoded from the state.
    always_comb begin
        last    = (st_q != SQ_IDLE) && (left_q == CW'(1));
        done_rd = last && (st_q == SQ_READ);
        done_lk = last && (st_q == SQ_LOCK);
        busy    = (st_q != SQ_IDLE);
        halt    = (st_q == SQ_LOCK);
    end
endmodule

// File: rtl/nvmc_store.sv
// Fuse and lock storage. The fuses load fixed values at reset. The lock byte can only lose 1 bits.
// Assumes lock_we is a single-cycle strobe that comes from the sequencer.
module nvmc_store #(
    parameter int                     NUM_FUSES = 6,
    parameter logic [8*NUM_FUSES-1:0] FUSE_INIT = 48'hA5_3C_F0_0F_7E_E7,
    parameter logic [7:0]             LOCK_INIT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fuse_idx,
    output logic [7:0] fuse_byte,
    input  logic       lock_we,
    input  logic [7:0] lock_req,
    output logic [7:0] lock_q,
    output logic       pgbuf_clr
);
    localparam int IW = (NUM_FUSES > 1) ? $clog2(NUM_FUSES) : 1;

    logic [NUM_FUSES-1:0][7:0] fuse_q;

    // Fuse cells: load the defaults at reset and hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_q <= FUSE_INIT;
        end
    end

    // Indexed fuse read. An index beyond the last fuse returns the erased value.
    always_comb begin
        if (int'(fuse_idx) < NUM_FUSES) begin
            fuse_byte = fuse_q[fuse_idx[IW-1:0]];
        end else begin
            fuse_byte = 8'hFF;
        end
    end

    // Lock update that can only clear bits, plus the page-buffer clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q    <= LOCK_INIT;
            pgbuf_clr <= 1'b0;
        end else begin
            pgbuf_clr <= lock_we;
            if (lock_we) begin
                lock_q <= lock_q & lock_req;
            end
        end
    end
endmodule

// File: rtl/nvm_cfg_ctrl.sv
// Top: register file, command decode and the read mux of the configuration controller.
// Assumes a single-cycle write strobe and a combinational read path.
module nvm_cfg_ctrl
    import nvmc_pkg::*;
#(
    parameter int                     NUM_FUSES   = 6,
    parameter logic [8*NUM_FUSES-1:0] FUSE_INIT   = 48'hA5_3C_F0_0F_7E_E7,
    parameter logic [7:0]             LOCK_INIT   = 8'hFF,
    parameter int                     READ_LAT    = 2,
    parameter int                     LOCK_CYCLES = 16,
    parameter int                     WIN_LEN     = 4,
    parameter logic [7:0]             UNLOCK_KEY  = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        cpu_halt,
    output logic        pgbuf_clr,
    output logic [7:0]  lock_bits
);
    logic [6:0] cmd_q;
    logic [7:0] idx_q;
    logic [7:0] data_q;
    logic       wr_ok;
    logic       key_hit;
    logic       exec_req;
    logic       start_rd;
    logic       start_lk;
    logic       win_open;
    logic       done_rd;
    logic       done_lk;
    logic [7:0] fuse_byte;

    // Decode of accepted writes and of command launches.
    always_comb begin
        wr_ok    = wr_en && !busy;
        key_hit  = wr_ok && (wr_addr == A_KEY) && (wr_data == UNLOCK_KEY);
        exec_req = wr_ok && (wr_addr == A_CTRL) && wr_data[0];
        start_rd = exec_req && (cmd_q == CMD_RD_FUSE);
        start_lk = exec_req && (cmd_q == CMD_WR_LOCK) && win_open;
    end

    // Software-visible command, index and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            idx_q  <= '0;
            data_q <= '0;
        end else if (done_rd) begin
            data_q <= fuse_byte;
        end else if (wr_ok) begin
            case (wr_addr)
                A_CMD:   cmd_q  <= wr_data[6:0];
                A_IDX:   idx_q  <= wr_data;
                A_DATA:  data_q <= wr_data;
                default: ;
            endcase
        end
    end

    nvmc_unlock_win #(.WIN_LEN(WIN_LEN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_hit  (key_hit),
        .win_open (win_open)
    );

    nvmc_seq #(.READ_LAT(READ_LAT), .LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (start_rd),
        .start_lk (start_lk),
        .busy     (busy),
        .halt     (cpu_halt),
        .done_rd  (done_rd),
        .done_lk  (done_lk)
    );

    nvmc_store #(.NUM_FUSES(NUM_FUSES), .FUSE_INIT(FUSE_INIT), .LOCK_INIT(LOCK_INIT)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fuse_idx  (idx_q),
        .fuse_byte (fuse_byte),
        .lock_we   (done_lk),
        .lock_req  (data_q),
        .lock_q    (lock_bits),
        .pgbuf_clr (pgbuf_clr)
    );

    // Register read mux. The execute bit reads back as the busy state.
    always_comb begin
        case (rd_addr)
            A_CMD:   rd_data = {1'b0, cmd_q};
            A_CTRL:  rd_data = {7'b0, busy};
            A_IDX:   rd_data = idx_q;
            A_DATA:  rd_data = data_q;
            A_STAT:  rd_data = {7'b0, busy};
            A_LOCK:  rd_data = lock_bits;
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/nvmc_chk.sv
// Protocol checker for nvm_cfg_ctrl, attached to it with a bind.
module nvmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cpu_halt,
    input logic       pgbuf_clr,
    input logic [7:0] lock_bits,
    input logic [6:0] cmd_q,
    input logic       win_open,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data
);
    p_halt_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> busy);

    p_lock_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_bits & ~$past(lock_bits)) == 8'h00);

    p_clr_after_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pgbuf_clr |-> ($past(cpu_halt) && !cpu_halt));

    p_lock_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> $past(win_open));

    p_nop_stays_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_addr == 3'd1 && wr_data[0] && cmd_q == 7'h00) |=> !busy);

    p_busy_freezes_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q));
endmodule

bind nvm_cfg_ctrl nvmc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cpu_halt  (cpu_halt),
    .pgbuf_clr (pgbuf_clr),
    .lock_bits (lock_bits),
    .cmd_q     (cmd_q),
    .win_open  (win_open),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/nvm_cfg_ctrl_tb.sv
module nvm_cfg_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic       cpu_halt;
    logic       pgbuf_clr;
    logic [7:0] lock_bits;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    nvm_cfg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cpu_halt(cpu_halt),
        .pgbuf_clr(pgbuf_clr), .lock_bits(lock_bits)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int         m_left = 0;
    int         m_kind = 0;   // 0 none, 1 fuse read, 2 lock write
    int         m_win  = 0;
    logic [6:0] m_cmd  = '0;
    logic [7:0] m_idx  = '0;
    logic [7:0] m_data = '0;
    logic [7:0] m_lock = 8'hFF;
    logic       m_clr  = 1'b0;
    bit         m_open;

    function automatic logic [7:0] fuse_exp(input logic [7:0] i);
        case (i)
            8'd0: return 8'hE7;
            8'd1: return 8'h7E;
            8'd2: return 8'h0F;
            8'd3: return 8'hF0;
            8'd4: return 8'h3C;
            8'd5: return 8'hA5;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] rd_exp(input logic [2:0] a);
        case (a)
            3'd0: return {1'b0, m_cmd};
            3'd1: return {7'b0, m_left > 0};
            3'd2: return m_idx;
            3'd3: return m_data;
            3'd4: return {7'b0, m_left > 0};
            3'd5: return m_lock;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_kind = 0; m_win = 0; m_cmd = '0; m_idx = '0;
            m_data = '0; m_lock = 8'hFF; m_clr = 1'b0;
        end else begin
            m_open = (m_win > 0);
            m_clr  = 1'b0;
            if (m_win > 0) m_win--;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_kind == 1) m_data = fuse_exp(m_idx);
                    else begin m_lock = m_lock & m_data; m_clr = 1'b1; end
                    m_kind = 0;
                end
            end else if (wr_en) begin
                case (wr_addr)
                    3'd0: m_cmd = wr_data[6:0];
                    3'd2: m_idx = wr_data;
                    3'd3: m_data = wr_data;
                    3'd6: if (wr_data == 8'h5A) m_win = 4;
                    3'd1: if (wr_data[0]) begin
                        if (m_cmd == 7'h07) begin m_left = 2; m_kind = 1; end
                        else if (m_cmd == 7'h08 && m_open) begin m_left = 16; m_kind = 2; end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare outputs with the model every cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R4 busy",     {7'b0, busy},      {7'b0, m_left > 0});
            chk("R5 halt",     {7'b0, cpu_halt},  {7'b0, m_kind == 2});
            chk("R7 pgbuf",    {7'b0, pgbuf_clr}, {7'b0, m_clr});
            chk("R6 lock",     lock_bits,         m_lock);
            chk("R1 readback", rd_data,           rd_exp(rd_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); rd_addr = a; #2; v = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R10 reset state
        rd(3'd5, v); chk("R10 lock reset", v, 8'hFF);
        rd(3'd0, v); chk("R10 cmd reset", v, 8'h00);
        chk("R10 busy reset", {7'b0, busy}, 8'h00);
        // R9 nop and an undefined code never set busy
        wr(3'd0, 8'h00); wr(3'd1, 8'h01);
        chk("R9 nop idle", {7'b0, busy}, 8'h00);
        wr(3'd0, 8'h15); wr(3'd1, 8'h01);
        chk("R9 undefined idle", {7'b0, busy}, 8'h00);
        // R1 bit 7 of the command register reads 0
        wr(3'd0, 8'hFF); rd(3'd0, v); chk("R1 cmd width", v, 8'h7F);
        // R2 fuse read, index 2
        wr(3'd0, 8'h07); wr(3'd2, 8'h02);
        rd_addr = 3'd1;
        wr(3'd1, 8'h01);
        chk("R9 exec reads 1", rd_data, 8'h01);
        // R8 writes during busy ignored
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h05;
        @(negedge clk); wr_en = 1'b0;
        rd(3'd2, v); chk("R8 index kept", v, 8'h02);
        rd(3'd3, v); chk("R2 fuse2", v, 8'h0F);
        rd(3'd1, v); chk("R9 exec self-clear", v, 8'h00);
        // R2 out-of-range index and another byte
        wr(3'd2, 8'h07); wr(3'd1, 8'h01); idle(3);
        rd(3'd3, v); chk("R2 out of range", v, 8'hFF);
        wr(3'd2, 8'h05); wr(3'd1, 8'h01); idle(3);
        rd(3'd3, v); chk("R2 fuse5", v, 8'hA5);
        // R3 lock write without the key is ignored
        wr(3'd0, 8'h08); wr(3'd3, 8'hF0); wr(3'd1, 8'h01);
        chk("R3 no key idle", {7'b0, busy}, 8'h00);
        // R3 key, then execute one edge past the window
        wr(3'd6, 8'h5A); idle(3); wr(3'd1, 8'h01);
        chk("R3 late exec idle", {7'b0, busy}, 8'h00);
        // R3 wrong key value
        wr(3'd6, 8'h5B); wr(3'd1, 8'h01);
        chk("R3 wrong key idle", {7'b0, busy}, 8'h00);
        // R3 execute on the last edge of the window
        wr(3'd6, 8'h5A); idle(2); wr(3'd1, 8'h01);
        chk("R5 halt during lock", {7'b0, cpu_halt}, 8'h01);
        wr(3'd6, 8'h5A); // R8 a key write during busy is ignored
        idle(16);
        rd(3'd5, v); chk("R6 lock cleared bits", v, 8'hF0);
        chk("R5 halt released", {7'b0, cpu_halt}, 8'h00);
        // R6 all-ones write cannot raise bits
        wr(3'd3, 8'hFF); wr(3'd6, 8'h5A); wr(3'd1, 8'h01); idle(18);
        rd(3'd5, v); chk("R6 no raise", v, 8'hF0);
        // R6 further lowering
        wr(3'd3, 8'h3C); wr(3'd6, 8'h5A); wr(3'd1, 8'h01); idle(18);
        rd(3'd5, v); chk("R6 and", v, 8'h30);
        rd(3'd7, v); chk("R1 unused addr", v, 8'h00);
        idle(2);
        finish_run();
    end
endmodule